// File: doc/BRIEF.md
# Indexed Byte-Space Access Port

This block lets an external 8-bit processor with an asynchronous bus reach a 256-byte internal space through a single address line. The space holds control registers and buffer RAM. The processor first writes a byte with the address line low, and that byte becomes the internal pointer. Each later read or write with the address line high reaches the byte at the pointer, and the pointer then moves on by one. A block of N bytes therefore costs one pointer write and N data cycles.

The strobes, the address line and the write data are brought into the internal clock through a synchronizer chain. Each bus cycle that completes produces one internal access pulse. The pulse reports four things: the pointer used, whether the cycle was a write, whether it was a data access, and whether the byte lies in the register part or the buffer part of the space. Where registers end depends on a map select input. In host layout, registers take the low 16 bytes. In peripheral layout, registers take the low 64 bytes.

Top module: `idx_byte_port`

## Requirements
- R1: When reset is held, the pointer and all 256 bytes go to zero, `acc_stb` goes low and `bus_doe` goes low. A data read after reset therefore returns 0x00 from address 0x00.
- R2: A write cycle with `bus_a0`=0 loads the pointer with the written byte and leaves memory unchanged.
- R3: A write cycle with `bus_a0`=1 stores the byte at the pointer, and the pointer then increments by one.
- R4: While `bus_cs_n`=0, `bus_rd_n`=0 and `bus_a0`=1, `bus_doe`=1 and `bus_dout` carries the byte at the pointer. When that read cycle completes, the pointer increments by one.
- R5: A read cycle with `bus_a0`=0 keeps `bus_doe`=0 and `bus_dout`=0x00, and it leaves the pointer unchanged. Whenever `bus_doe`=0, `bus_dout` is 0x00.
- R6: The pointer wraps from 0xFF to 0x00 when it increments.
- R7: Each completed bus cycle raises `acc_stb` for exactly one clock. In that clock, `acc_addr` is the pointer in effect during the cycle, `acc_write`=1 for write cycles, and `acc_data`=1 when `bus_a0` was 1.
- R8: A write cycle ends on whichever of `bus_wr_n` or `bus_cs_n` rises first. The byte present while both were low is the one captured, and any later change on `bus_din` is ignored.
- R9: With `map_periph`=0, `acc_is_reg`=1 for addresses 0x00–0x0F and 0 for 0x10–0xFF.
- R10: With `map_periph`=1, `acc_is_reg`=1 for addresses 0x00–0x3F and 0 for 0x40–0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| map_periph | input | 1 | Map select: 0 = host layout, 1 = peripheral layout |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_a0 | input | 1 | 0 = pointer cycle, 1 = data cycle |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data to the processor |
| bus_doe | output | 1 | Output enable for the external data pad |
| acc_stb | output | 1 | One-clock pulse for each completed cycle |
| acc_addr | output | 8 | Pointer in effect during the reported cycle |
| acc_write | output | 1 | Reported cycle was a write |
| acc_data | output | 1 | Reported cycle had `bus_a0`=1 |
| acc_is_reg | output | 1 | Reported address lies in the register part |

## Verification
The assertions rely on two conditions of the processor. The read and write strobes are never active together under chip select. Each strobe stays active and inactive for at least the depth of the synchronizer, so that every cycle is seen as one clean rise and one clean fall. The bench drives each strobe for three clocks and leaves at least five idle clocks between cycles. It changes `map_periph` only while the bus is idle. It holds address and data from before the strobe falls until after it rises, except in the one R8 case, where the data changes on purpose once chip select has risen.

// File: rtl/idx_port_pkg.sv
// Package: shared operation type and address-region decode for the
// indexed byte-space port. Assumes the pointer is as wide as a data byte.
package idx_port_pkg;

    // Kind of bus cycle that has just completed
    typedef enum logic [1:0] {
        OP_PTR_LOAD = 2'd0,
        OP_DATA_WR  = 2'd1,
        OP_DATA_RD  = 2'd2,
        OP_NULL_RD  = 2'd3
    } port_op_e;

    // True when addr falls in the register part of the selected layout
    function automatic logic region_is_reg(input logic [7:0] addr,
                                           input logic       periph,
                                           input int unsigned host_lim,
                                           input int unsigned periph_lim);
        int unsigned lim;
        lim = periph ? periph_lim : host_lim;
        return (32'(addr) < lim);
    endfunction

endpackage

// File: rtl/idx_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous bus inputs.
// Assumes the bus holds each bit steady long enough to be sampled;
// the bits travel side by side so they keep their alignment.
module idx_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Each later stage retimes the stage before it
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/idx_cycle_detect.sv
// Module: finds the end of each bus cycle from synchronized strobes and
// classifies it. Assumes read and write are never active together.
// The address bit and data are held from the last clock the strobe was seen.
module idx_cycle_detect
    import idx_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act_s,
    input  logic              rd_act_s,
    input  logic              a0_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              done,
    output port_op_e          op,
    output logic [DATA_W-1:0] din_held
);
    logic wr_q, rd_q, a0_held;
    logic wr_end, rd_end;

    // Remember last strobe state; hold address bit and data while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            a0_held  <= 1'b0;
            din_held <= '0;
        end else begin
            wr_q <= wr_act_s;
            rd_q <= rd_act_s;
            if (wr_act_s || rd_act_s) begin
                a0_held  <= a0_s;
                din_held <= din_s;
            end
        end
    end

    // Cycle ends on the falling edge of the synchronized activity
    always_comb begin
        wr_end = wr_q && !wr_act_s;
        rd_end = rd_q && !rd_act_s;
        done   = wr_end || rd_end;
        if (wr_end) op = a0_held ? OP_DATA_WR : OP_PTR_LOAD;
        else        op = a0_held ? OP_DATA_RD : OP_NULL_RD;
    end

    // R7: input rule, read and write never active at once
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act_s && rd_act_s));

    // R7: a completed cycle is never reported on two consecutive clocks
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/idx_pointer.sv
// Module: the auto-advancing address pointer. It loads on a pointer cycle,
// steps by one on each data cycle, wraps at the top and stays put otherwise.
module idx_pointer
    import idx_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  port_op_e          op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    // Update the pointer when a cycle completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (done) begin
            unique case (op)
                OP_PTR_LOAD: ptr <= load_val;
                OP_DATA_WR,
                OP_DATA_RD:  ptr <= ptr + 1'b1;
                default:     ptr <= ptr;
            endcase
        end
    end

    // R2: a pointer cycle leaves the written byte in the pointer
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_PTR_LOAD) |=> ptr == $past(load_val));

    // R3: a data cycle moves the pointer on by one
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op == OP_DATA_WR || op == OP_DATA_RD))
            |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R5: a read with the address bit low does not move the pointer
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_NULL_RD) |=> $stable(ptr));

    // R6: stepping from the top address lands on zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_DATA_WR && ptr == TOP) |=> ptr == '0);
endmodule

// File: rtl/idx_store.sv
// Module: the 256-byte space as a plain byte array, plus the registered
// access report with its register/buffer flag. Assumes the map select
// changes only while the bus is idle.
module idx_store
    import idx_port_pkg::*;
#(
    parameter int ADDR_W           = 8,
    parameter int DATA_W           = 8,
    parameter int HOST_REG_BYTES   = 16,
    parameter int PERIPH_REG_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_periph,
    input  logic              done,
    input  port_op_e          op,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rd_byte,
    output logic              acc_stb,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_write,
    output logic              acc_data,
    output logic              acc_is_reg
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear the space on reset; store the byte on a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (done && op == OP_DATA_WR) begin
            mem[ptr] <= wr_byte;
        end
    end

    // The byte under the pointer is always presented for reads
    assign rd_byte = mem[ptr];

    // Register the access report for one clock per completed cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_stb    <= 1'b0;
            acc_addr   <= '0;
            acc_write  <= 1'b0;
            acc_data   <= 1'b0;
            acc_is_reg <= 1'b0;
        end else begin
            acc_stb <= done;
            if (done) begin
                acc_addr   <= ptr;
                acc_write  <= (op == OP_PTR_LOAD) || (op == OP_DATA_WR);
                acc_data   <= (op == OP_DATA_WR) || (op == OP_DATA_RD);
                acc_is_reg <= region_is_reg(ptr, map_periph,
                                            HOST_REG_BYTES, PERIPH_REG_BYTES);
            end
        end
    end

    // R7: every report pulse lasts exactly one clock
    a_r7_stb_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |=> !acc_stb);

    // R7: the report follows a completed cycle by one clock
    a_r7_stb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> acc_stb);
endmodule

// File: rtl/idx_byte_port.sv
// Module: top of the indexed byte-space access port. It synchronizes the
// asynchronous processor bus, detects completed cycles, steps the pointer
// and reaches the byte store. Assumes strobes stay active and inactive for
// at least the synchronizer depth, and that the external pad uses bus_doe.
module idx_byte_port
    import idx_port_pkg::*;
#(
    parameter int DATA_W           = 8,
    parameter int SYNC_STAGES      = 2,
    parameter int HOST_REG_BYTES   = 16,
    parameter int PERIPH_REG_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_periph,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic              bus_a0,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              acc_stb,
    output logic [DATA_W-1:0] acc_addr,
    output logic              acc_write,
    output logic              acc_data,
    output logic              acc_is_reg
);
    localparam int ADDR_W = DATA_W;
    localparam int SYNC_W = DATA_W + 3;

    logic [SYNC_W-1:0] raw_vec, sync_vec;
    logic              wr_act_s, rd_act_s, a0_s;
    logic [DATA_W-1:0] din_s, din_held, rd_byte;
    logic [ADDR_W-1:0] ptr;
    logic              done;
    port_op_e          op;
    logic              rd_window;

    // Combine chip select with each strobe before synchronizing
    assign raw_vec = {!bus_cs_n && !bus_wr_n, !bus_cs_n && !bus_rd_n, bus_a0, bus_din};

    idx_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_vec), .d_sync(sync_vec)
    );

    assign {wr_act_s, rd_act_s, a0_s, din_s} = sync_vec;

    idx_cycle_detect #(.DATA_W(DATA_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .wr_act_s(wr_act_s), .rd_act_s(rd_act_s),
        .a0_s(a0_s), .din_s(din_s), .done(done), .op(op), .din_held(din_held)
    );

    idx_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .done(done), .op(op),
        .load_val(din_held[ADDR_W-1:0]), .ptr(ptr)
    );

    idx_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .HOST_REG_BYTES(HOST_REG_BYTES), .PERIPH_REG_BYTES(PERIPH_REG_BYTES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .map_periph(map_periph), .done(done), .op(op),
        .ptr(ptr), .wr_byte(din_held), .rd_byte(rd_byte),
        .acc_stb(acc_stb), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_data(acc_data), .acc_is_reg(acc_is_reg)
    );

    // Drive read data only during a data read; otherwise present zero
    always_comb begin
        rd_window = !bus_cs_n && !bus_rd_n && bus_a0;
        bus_doe   = rd_window;
        bus_dout  = rd_window ? rd_byte : '0;
    end

    // R5: an undriven data bus always reads as zero
    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_doe |-> bus_dout == '0);
endmodule

// File: tb/test_idx_byte_port.sv
module test_idx_byte_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       map_periph = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1, bus_a0 = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, acc_addr;
    logic       bus_doe, acc_stb, acc_write, acc_data, acc_is_reg;

    int n_chk = 0, n_bad = 0, n_pulse = 0, n_issued = 0;
    logic [7:0] last_addr;
    logic       last_write, last_data, last_reg;
    bit         finished = 0;

    always #2 clk = ~clk;

    idx_byte_port i_idx_byte_port (
        .clk(clk), .rst_n(rst_n), .map_periph(map_periph),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_a0(bus_a0), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .acc_stb(acc_stb), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_data(acc_data), .acc_is_reg(acc_is_reg)
    );

    // Record every report pulse away from the active edge
    always @(negedge clk) begin
        if (rst_n && acc_stb) begin
            n_pulse++;
            last_addr  = acc_addr;
            last_write = acc_write;
            last_data  = acc_data;
            last_reg   = acc_is_reg;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus cycle; for reads the data bus is checked mid-cycle
    task automatic bus_cycle(input bit rd, input bit a0, input logic [7:0] d,
                             input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_a0 = a0; bus_din = d; bus_cs_n = 0;
        if (rd) bus_rd_n = 0; else bus_wr_n = 0;
        idle(3);
        if (rd) begin
            chk({req, " output enable"}, 32'(bus_doe), 32'(a0));
            chk({req, " read data"}, 32'(bus_dout), 32'(exp));
        end
        bus_rd_n = 1; bus_wr_n = 1; bus_cs_n = 1;
        n_issued++;
        idle(6);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Vector: {rd, a0, data, expected read byte}
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h10, 8'h00},  // R2 pointer to 0x10
        {1'b0, 1'b1, 8'h80, 8'h00},  // R3 store 0x80 at 0x10
        {1'b0, 1'b1, 8'h06, 8'h00},  // R3 store 0x06 at 0x11
        {1'b0, 1'b0, 8'h10, 8'h00},  // R2 pointer back to 0x10
        {1'b1, 1'b1, 8'h00, 8'h80},  // R4 read 0x10
        {1'b1, 1'b1, 8'h00, 8'h06},  // R4 read 0x11
        {1'b1, 1'b0, 8'h00, 8'h00},  // R5 read with A0 low, no drive
        {1'b1, 1'b1, 8'h00, 8'h00},  // R5 pointer held at 0x12, unwritten
        {1'b0, 1'b0, 8'hFF, 8'h00},  // R2 pointer to 0xFF
        {1'b0, 1'b1, 8'h5A, 8'h00},  // R3 store at 0xFF
        {1'b0, 1'b1, 8'hA5, 8'h00},  // R6 wrapped store at 0x00
        {1'b0, 1'b0, 8'hFF, 8'h00},  // R2 pointer to 0xFF
        {1'b1, 1'b1, 8'h00, 8'h5A},  // R4 read 0xFF
        {1'b1, 1'b1, 8'h00, 8'hA5}   // R6 read wraps to 0x00
    };

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        idle(4);
        // R1: reset state
        chk("R1 acc_stb in reset", 32'(acc_stb), 0);
        chk("R1 doe in reset", 32'(bus_doe), 0);
        rst_n = 1;
        idle(2);
        bus_cycle(1, 1, 8'h00, 8'h00, "R1 first read at 0x00");

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            bus_cycle(VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0],
                      $sformatf("R4 vector %0d", v));
        end
        chk("R7 pulse count", 32'(n_pulse), 32'(n_issued));

        // R7: report fields for a pointer write and a data write
        bus_cycle(0, 0, 8'h20, 8'h00, "R7 load");
        chk("R7 addr of load", 32'(last_addr), 32'h01);
        chk("R7 write flag of load", 32'(last_write), 1);
        chk("R7 data flag of load", 32'(last_data), 0);
        bus_cycle(0, 1, 8'h33, 8'h00, "R7 store");
        chk("R7 addr of store", 32'(last_addr), 32'h20);
        chk("R7 data flag of store", 32'(last_data), 1);
        bus_cycle(1, 0, 8'h00, 8'h00, "R7 null read");
        chk("R7 write flag of read", 32'(last_write), 0);

        // R8: chip select rises first, data changes before write strobe rises
        bus_cycle(0, 0, 8'h30, 8'h00, "R8 ptr");
        @(negedge clk);
        bus_a0 = 1; bus_din = 8'hC3; bus_cs_n = 0; bus_wr_n = 0;
        idle(3);
        bus_cs_n = 1;
        idle(1);
        bus_din = 8'hEE;
        idle(2);
        bus_wr_n = 1;
        n_issued++;
        idle(6);
        bus_cycle(0, 0, 8'h30, 8'h00, "R8 ptr again");
        bus_cycle(1, 1, 8'h00, 8'hC3, "R8 captured byte");

        // R9: host layout boundary
        bus_cycle(0, 0, 8'h0F, 8'h00, "R9 ptr");
        bus_cycle(0, 1, 8'h11, 8'h00, "R9 store 0x0F");
        chk("R9 0x0F is register", 32'(last_reg), 1);
        bus_cycle(0, 1, 8'h22, 8'h00, "R9 store 0x10");
        chk("R9 0x10 is buffer", 32'(last_reg), 0);

        // R10: peripheral layout boundary
        map_periph = 1;
        idle(2);
        bus_cycle(0, 0, 8'h3F, 8'h00, "R10 ptr");
        bus_cycle(1, 1, 8'h00, 8'h00, "R10 read 0x3F");
        chk("R10 0x3F is register", 32'(last_reg), 1);
        bus_cycle(1, 1, 8'h00, 8'h00, "R10 read 0x40");
        chk("R10 0x40 is buffer", 32'(last_reg), 0);
        bus_cycle(0, 0, 8'h10, 8'h00, "R10 ptr 0x10");
        bus_cycle(1, 1, 8'h00, 8'h22, "R10 read 0x10");
        chk("R10 0x10 is register", 32'(last_reg), 1);
        chk("R7 total pulses", 32'(n_pulse), 32'(n_issued));

        // R1: reset mid-run clears pointer and memory (0x00 held 0xA5)
        @(negedge clk);
        rst_n = 0;
        idle(3);
        chk("R1 acc_stb after reset", 32'(acc_stb), 0);
        rst_n = 1;
        idle(2);
        bus_cycle(1, 1, 8'h00, 8'h00, "R1 memory cleared");

        finished = 1;
        finish_run();
    end
endmodule